// File: doc/BRIEF.md
# Tape Record Framer with Biphase Write Encoder

This block turns one tape record into a single-wire biphase-level bit stream for a cassette write head. A start strobe launches the record. A mode bit picks between a formatting pass and an update pass. The formatting pass lays down the whole frame: leading sync, record number, second sync, a data field filled with ones, checksum and trailing sync. The update pass assumes the record number on tape has already been read back and verified. It begins at the second sync and takes its data field from an external byte buffer.

Timing is set by a half-cell enable pulse from outside the block. Each pulse ends one half of a bit cell, so the same logic works at any tape speed. At every one of those pulses the block samples three transport status lines: stall, cassette present and end of tape. Any fault stops the write at once, holds the line level and raises a sticky error flag. The buffer port is read one byte ahead, with a one-cycle read latency, so block RAM can sit directly behind it.

Top module: `tape_rec_writer`

## Requirements
- R1: After synchronous reset, `wr_line`, `busy`, `done`, `err` and `buf_rd` are all 0.
- R2: With `fmt_mode`=1 the record is NBYTES+5 bytes, in this order: sync, the record number captured at start, sync, NBYTES data bytes, checksum, sync.
- R3: In format mode every data byte is 0xFF and the buffer port is never read (`buf_rd` stays 0), whatever the buffer holds.
- R4: With `fmt_mode`=0 the record is NBYTES+3 bytes: sync, buffer bytes from address 0 upward, checksum, sync. No leading sync and no record number are sent.
- R5: The checksum byte is the sum, modulo 256, of the data bytes emitted in that record.
- R6: Each bit takes two half-cells. The first half carries the inverse of the bit and the second half carries the bit, so a 1 rises at mid-cell and a 0 falls. Bytes go MSB first. `wr_line` changes only at a start or at a `half_tick`.
- R7: A record takes exactly 16 half-cells per byte, whatever the data values.
- R8: The sync byte is 0xAA. Its alternating bits give mid-cell transitions only, with no transition at any cell edge inside it.
- R9: The `half_tick` that closes the final half-cell clears `busy` and pulses `done` for one cycle on that edge. `wr_line` then holds its level.
- R10: If stall=1, present=0 or eot=1 at a `half_tick` while busy, that edge clears `busy`, sets `err` and gives no `done`. The line holds until the next start, and the next start clears `err`.
- R11: A start while `busy` is ignored. The running record keeps its mode, length and content.
- R12: The buffer port has a one-cycle latency. Each data byte is requested with a single `buf_rd` cycle before it is needed, so an update record performs exactly NBYTES reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a record (ignored while busy) |
| fmt_mode | input | 1 | 1 = format pass, 0 = update pass |
| rec_num | input | 8 | Record number, captured at start |
| half_tick | input | 1 | One-cycle enable at the half-cell rate |
| stall | input | 1 | Transport stall status |
| present | input | 1 | Cassette present status |
| eot | input | 1 | End-of-tape status |
| buf_rd | output | 1 | Buffer read enable |
| buf_addr | output | $clog2(NBYTES) | Buffer byte address |
| buf_rdata | input | 8 | Buffer data, valid the cycle after buf_rd |
| wr_line | output | 1 | Encoded write data level |
| busy | output | 1 | Record in progress |
| done | output | 1 | One-cycle pulse on normal completion |
| err | output | 1 | Sticky abort flag, cleared by start |

## Verification
The first half-cell level appears on the clock edge that accepts the start. Every later half-cell level appears on the edge that samples `half_tick`. The bench therefore reads `wr_line` on the falling edge right after each of those edges and rebuilds the record one half-cell at a time. `done`, `busy`=0 and `err` are due on the same edge as the closing or faulting tick, and are sampled at that same falling edge. A buffer byte is ready two cycles after its request, well before the next byte boundary 16 ticks later. For that reason the bench packs ticks back to back in some runs and spaces them in others, and in both cases checks the content against the expected frame.

// File: rtl/twr_pkg.sv
package twr_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // Field of the byte currently in the shifter
  typedef enum logic [2:0] {
    F_LEAD_SYNC,
    F_REC_NUM,
    F_MID_SYNC,
    F_PAYLOAD,
    F_SUM,
    F_TAIL_SYNC
  } field_e;
endpackage

// File: rtl/twr_seq.sv
module twr_seq
  import twr_pkg::*;
#(
  parameter int    NBYTES    = 256,
  parameter byte_t SYNC_BYTE = 8'hAA,
  localparam int   AW        = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_go,
  input  logic          fmt_i,
  input  byte_t         rnum_i,
  input  logic          take,
  output byte_t         first_byte,
  output byte_t         succ_byte,
  output logic          succ_none,
  output logic          fmt_q,
  output logic          buf_rd,
  output logic [AW-1:0] buf_addr,
  input  byte_t         buf_rdata
);
  localparam logic [AW-1:0] LAST = AW'(NBYTES - 1);

  field_e        cur, nxt;
  logic [AW-1:0] idx, nidx;
  byte_t         csum, pre_q, rnum_q, dbyte;
  logic          rd_q, cap_q;
  logic [AW-1:0] addr_q;

  assign first_byte = SYNC_BYTE;
  assign dbyte      = fmt_q ? 8'hFF : pre_q;
  assign nidx       = (cur == F_MID_SYNC) ? '0 : idx + 1'b1;

  always_comb begin
    nxt       = cur;
    succ_byte = SYNC_BYTE;
    succ_none = 1'b0;
    unique case (cur)
      F_LEAD_SYNC: begin nxt = F_REC_NUM;  succ_byte = rnum_q;    end
      F_REC_NUM:   begin nxt = F_MID_SYNC; succ_byte = SYNC_BYTE; end
      F_MID_SYNC:  begin nxt = F_PAYLOAD;  succ_byte = dbyte;     end
      F_PAYLOAD: begin
        if (idx == LAST) begin nxt = F_SUM; succ_byte = csum; end
        else             begin nxt = F_PAYLOAD; succ_byte = dbyte; end
      end
      F_SUM:       begin nxt = F_TAIL_SYNC; succ_byte = SYNC_BYTE; end
      F_TAIL_SYNC: begin succ_none = 1'b1; end
      default:     begin succ_none = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur    <= F_TAIL_SYNC;
      idx    <= '0;
      csum   <= '0;
      pre_q  <= '0;
      rnum_q <= '0;
      fmt_q  <= 1'b0;
      rd_q   <= 1'b0;
      cap_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      cap_q <= rd_q;
      rd_q  <= 1'b0;
      if (cap_q) pre_q <= buf_rdata;
      if (start_go) begin
        cur    <= fmt_i ? F_LEAD_SYNC : F_MID_SYNC;
        fmt_q  <= fmt_i;
        rnum_q <= rnum_i;
        csum   <= '0;
        idx    <= '0;
        rd_q   <= ~fmt_i;
        addr_q <= '0;
      end else if (take) begin
        cur <= nxt;
        if (nxt == F_PAYLOAD) begin
          idx  <= nidx;
          csum <= csum + dbyte;
          if (!fmt_q && nidx != LAST) begin
            rd_q   <= 1'b1;
            addr_q <= nidx + 1'b1;
          end
        end
      end
    end
  end

  assign buf_rd   = rd_q;
  assign buf_addr = addr_q;
endmodule

// File: rtl/twr_enc.sv
module twr_enc
  import twr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start_go,
  input  logic  tick,
  input  logic  halt,
  input  byte_t first_byte,
  input  byte_t succ_byte,
  input  logic  succ_none,
  output logic  line,
  output logic  active,
  output logic  phase,
  output logic  take,
  output logic  fin
);
  byte_t      sh;
  logic [2:0] bitc;
  logic       step, cell_end;

  assign step     = active && tick && !halt;
  assign cell_end = step && phase && (bitc == 3'd7);
  assign take     = cell_end && !succ_none;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      bitc   <= '0;
      phase  <= 1'b0;
      active <= 1'b0;
      line   <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start_go) begin
        sh     <= first_byte;
        bitc   <= '0;
        phase  <= 1'b0;
        active <= 1'b1;
        line   <= ~first_byte[BYTE_W-1];
      end else if (active && tick && halt) begin
        active <= 1'b0;
      end else if (step) begin
        if (!phase) begin
          phase <= 1'b1;
          line  <= sh[BYTE_W-1];
        end else if (bitc != 3'd7) begin
          sh    <= {sh[BYTE_W-2:0], 1'b0};
          bitc  <= bitc + 1'b1;
          phase <= 1'b0;
          line  <= ~sh[BYTE_W-2];
        end else if (!succ_none) begin
          sh    <= succ_byte;
          bitc  <= '0;
          phase <= 1'b0;
          line  <= ~succ_byte[BYTE_W-1];
        end else begin
          active <= 1'b0;
          fin    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/twr_guard.sv
module twr_guard (
  input  logic clk,
  input  logic rst,
  input  logic start_go,
  input  logic tick,
  input  logic active,
  input  logic stall,
  input  logic present,
  input  logic eot,
  output logic halt,
  output logic err
);
  assign halt = active && tick && (stall || !present || eot);

  always_ff @(posedge clk) begin
    if (rst)           err <= 1'b0;
    else if (start_go) err <= 1'b0;
    else if (halt)     err <= 1'b1;
  end
endmodule

// File: rtl/tape_rec_writer.sv
module tape_rec_writer
  import twr_pkg::*;
#(
  parameter int    NBYTES    = 256,
  parameter byte_t SYNC_BYTE = 8'hAA,
  localparam int   AW        = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          fmt_mode,
  input  logic [7:0]    rec_num,
  input  logic          half_tick,
  input  logic          stall,
  input  logic          present,
  input  logic          eot,
  output logic          buf_rd,
  output logic [AW-1:0] buf_addr,
  input  logic [7:0]    buf_rdata,
  output logic          wr_line,
  output logic          busy,
  output logic          done,
  output logic          err
);
  logic  start_go, take, halt, succ_none, fmt_run, enc_phase;
  byte_t first_byte, succ_byte;

  assign start_go = start && !busy;

  twr_seq #(.NBYTES(NBYTES), .SYNC_BYTE(SYNC_BYTE)) u_seq (
    .clk(clk), .rst(rst), .start_go(start_go), .fmt_i(fmt_mode),
    .rnum_i(rec_num), .take(take), .first_byte(first_byte),
    .succ_byte(succ_byte), .succ_none(succ_none), .fmt_q(fmt_run),
    .buf_rd(buf_rd), .buf_addr(buf_addr), .buf_rdata(buf_rdata)
  );

  twr_enc u_enc (
    .clk(clk), .rst(rst), .start_go(start_go), .tick(half_tick),
    .halt(halt), .first_byte(first_byte), .succ_byte(succ_byte),
    .succ_none(succ_none), .line(wr_line), .active(busy),
    .phase(enc_phase), .take(take), .fin(done)
  );

  twr_guard u_guard (
    .clk(clk), .rst(rst), .start_go(start_go), .tick(half_tick),
    .active(busy), .stall(stall), .present(present), .eot(eot),
    .halt(halt), .err(err)
  );
endmodule

// File: rtl/twr_check.sv
module twr_check (
  input logic clk,
  input logic rst,
  input logic start,
  input logic half_tick,
  input logic stall,
  input logic present,
  input logic eot,
  input logic busy,
  input logic done,
  input logic err,
  input logic wr_line,
  input logic buf_rd,
  input logic fmt_run,
  input logic enc_phase,
  input logic halt
);
  AST_LINE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (!half_tick && !(start && !busy)) |=> $stable(wr_line)); // R6

  AST_MID_CELL_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (busy && half_tick && !halt && !enc_phase) |=> (wr_line != $past(wr_line))); // R6

  AST_FAULT_ABORTS: assert property (@(posedge clk) disable iff (rst)
    (busy && half_tick && (stall || !present || eot)) |=> (!busy && err && !done)); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R9

  AST_NO_READ_IN_FORMAT: assert property (@(posedge clk) disable iff (rst)
    buf_rd |-> !fmt_run); // R3

  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !half_tick) |=> busy); // R11
endmodule

bind tape_rec_writer twr_check u_chk (
  .clk(clk), .rst(rst), .start(start), .half_tick(half_tick),
  .stall(stall), .present(present), .eot(eot), .busy(busy), .done(done),
  .err(err), .wr_line(wr_line), .buf_rd(buf_rd), .fmt_run(fmt_run),
  .enc_phase(enc_phase), .halt(halt)
);

// File: tb/tb_tape_rec_writer.sv
module tb_tape_rec_writer;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int AW = $clog2(NB);
  localparam logic [7:0] SYNC = 8'hAA;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 0, fmt_mode = 0, half_tick = 0, stall = 0, present = 1, eot = 0;
  logic [7:0] rec_num = 0;
  logic buf_rd, wr_line, busy, done, err;
  logic [AW-1:0] buf_addr;
  logic [7:0] buf_rdata = 0;
  logic [7:0] mem [NB];

  int total = 0, bad = 0, rdcnt = 0;
  logic halves [512];
  int nh;
  logic end_done, end_err, end_line;
  logic [7:0] expb [NB+5];
  int nexp;

  always #(CLK_PERIOD/2) clk = ~clk;

  tape_rec_writer #(.NBYTES(NB), .SYNC_BYTE(SYNC)) dut (
    .clk(clk), .rst(rst), .start(start), .fmt_mode(fmt_mode), .rec_num(rec_num),
    .half_tick(half_tick), .stall(stall), .present(present), .eot(eot),
    .buf_rd(buf_rd), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
    .wr_line(wr_line), .busy(busy), .done(done), .err(err)
  );

  always @(posedge clk) begin
    if (buf_rd) begin
      buf_rdata <= mem[buf_addr];
      rdcnt <= rdcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic build_exp(input bit fm, input logic [7:0] rn);
    logic [7:0] s = 0;
    nexp = 0;
    if (fm) begin expb[nexp++] = SYNC; expb[nexp++] = rn; end
    expb[nexp++] = SYNC;
    for (int i = 0; i < NB; i++) begin
      logic [7:0] d = fm ? 8'hFF : mem[i];
      expb[nexp++] = d;
      s = s + d;
    end
    expb[nexp++] = s;
    expb[nexp++] = SYNC;
  endtask

  task automatic run_rec(input bit fm, input logic [7:0] rn, input int gap,
                         input int fault_at, input int restart_at);
    @(negedge clk);
    fmt_mode = fm; rec_num = rn; start = 1;
    @(negedge clk);
    start = 0; rec_num = ~rn;
    halves[0] = wr_line; nh = 1;
    for (int k = 1; k < 2000; k++) begin
      repeat (gap) @(negedge clk);
      half_tick = 1;
      if (k == fault_at) stall = 1;
      if (k == restart_at) begin start = 1; fmt_mode = ~fm; end
      @(negedge clk);
      half_tick = 0; stall = 0; start = 0;
      if (!busy) break;
      halves[nh] = wr_line; nh++;
    end
    end_done = done; end_err = err; end_line = wr_line;
  endtask

  task automatic check_rec(input bit fm, input logic [7:0] rn, input int gap,
                           input int restart_at, input string tag);
    int rd0, errs, first;
    rd0 = rdcnt;
    build_exp(fm, rn);
    run_rec(fm, rn, gap, -1, restart_at);
    chk(nh == 16*nexp, restart_at > 0 ? "R11" : "R7", {tag, " half-cell count"}, nh, 16*nexp);
    errs = 0; first = -1;
    for (int i = 0; i < 16*nexp && i < nh; i++) begin
      logic b = expb[i/16][7 - (i%16)/2];
      logic lv = (i % 2) ? b : ~b;
      if (halves[i] !== lv) begin errs++; if (first < 0) first = i; end
    end
    chk(errs == 0, fm ? "R2 R5 R6" : "R4 R5 R6", {tag, " level mismatches (first idx in msg)"},
        errs, 0);
    if (errs != 0) $display("  first mismatching half-cell %0d", first);
    chk(end_done && !end_err, "R9", {tag, " done at final tick"}, end_done, 1);
    chk(rdcnt - rd0 == (fm ? 0 : NB), fm ? "R3" : "R12", {tag, " buffer reads"},
        rdcnt - rd0, fm ? 0 : NB);
    // R8: no edge transition inside the first sync byte
    errs = 0;
    for (int i = 1; i < 15; i += 2) if (halves[i] !== halves[i+1]) errs++;
    chk(errs == 0, "R8", {tag, " sync edge transitions"}, errs, 0);
    repeat (2) @(negedge clk);
    chk(wr_line === end_line && !done, "R9", {tag, " line held after end"}, wr_line, end_line);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!wr_line && !busy && !done && !err && !buf_rd, "R1", "reset state",
        {wr_line, busy, done, err, buf_rd}, 0);

    // Format passes: buffer holds garbage that must not appear (R3)
    for (int i = 0; i < NB; i++) mem[i] = 8'h3C + 8'(i);
    check_rec(1, 8'h00, 0, -1, "fmt rn=00 gap0");
    check_rec(1, 8'h5A, 2, -1, "fmt rn=5A gap2");
    check_rec(1, 8'hFF, 1, -1, "fmt rn=FF gap1");

    // Update passes over several data patterns and tick spacings
    for (int p = 0; p < 5; p++) begin
      for (int g = 0; g < 3; g += 2) begin
        logic [7:0] seed = 8'(17*p + 3);
        for (int i = 0; i < NB; i++) begin
          unique case (p)
            0: mem[i] = 8'h00;
            1: mem[i] = 8'hFF;
            2: mem[i] = 8'(i);
            default: begin seed = seed*8'd29 + 8'd71; mem[i] = seed; end
          endcase
        end
        check_rec(0, 8'h11, g, -1, $sformatf("upd pat%0d gap%0d", p, g));
      end
    end

    // R11: start while busy, with the other mode, has no effect
    check_rec(0, 8'h22, 1, 9, "upd restart ignored");
    check_rec(1, 8'h77, 0, 30, "fmt restart ignored");

    // R10: stall in mid record
    run_rec(0, 8'h00, 1, 20, -1);
    chk(nh == 20, "R10", "abort half-cell count", nh, 20);
    chk(end_err && !end_done, "R10", "abort err/no done", {end_err, end_done}, 2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); half_tick = 1; @(negedge clk); half_tick = 0;
    end
    chk(wr_line === end_line && err && !busy, "R10", "line held after abort", wr_line, end_line);

    // R10: missing cassette aborts at the first tick, start clears err
    present = 0;
    @(negedge clk); fmt_mode = 1; start = 1;
    @(negedge clk); start = 0;
    chk(!err && busy, "R10", "start clears err", err, 0);
    @(negedge clk); half_tick = 1; @(negedge clk); half_tick = 0;
    chk(err && !busy && !done, "R10", "no cassette abort", {err, busy, done}, 4);
    present = 1;

    // R10: end of tape abort
    @(negedge clk); eot = 1;
    run_rec(1, 8'h01, 0, -1, -1);
    chk(nh == 1 && end_err, "R10", "eot abort", nh, 1);
    eot = 0;

    check_rec(0, 8'h00, 0, -1, "upd after aborts");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule